// File: doc/BRIEF.md
# Stretch Stepper for Upscaling

This block produces the input-sample index for a scaler that makes more output samples than it reads in. Each output tick is one decision, made by an error-accumulator line-drawing step: either move on to the next input sample or repeat the current one. The same block serves along a scan line (pixels) or down a frame (lines). Any interpolation between neighbouring samples, and the memory fetch that follows the index, are handled by other logic.

Software writes three values through a small write port:

- the last input index, K1 = inputs − 1;
- the step delta, K2 = inputs − outputs, in two's complement;
- the accumulator seed.

These writes go into holding copies. They reach the working set only on a vertical-sync pulse, so a frame never runs with half-changed constants.

A reload pulse at the start of every line (or frame, for the vertical instance) restarts the walk from the seed.

Top module: `dda_stretch_stepper`

## Requirements
- R1: After reset, `idx` is 0 and `adv` is low. All holding and working constants are 0.
- R2: Configuration writes only update the holding copies. Stepping uses the working set, which ignores such writes until a vertical-sync pulse arrives. `cfg_sel` selects the target: 0 = K1 from `cfg_data[10:0]`, 1 = K2 from `cfg_data[10:0]`, 2 = seed from `cfg_data[11:0]`, 3 = no effect.
- R3: On a `vsync` cycle, all three holding values are copied into the working set. A write in that same cycle is held for the following sync.
- R4: A `line_start` cycle does three things:
  - loads the accumulator with the working seed, sign-extended from 12 bits;
  - clears `idx`;
  - drives `adv` low on the next cycle.
- R5: On a `tick` cycle where the accumulator is above zero, 2·K2 is added to the accumulator, with K2 read as a signed 11-bit value. If `idx` is below K1, `idx` also increments and `adv` is high for exactly the next cycle.
- R6: On a `tick` cycle where the accumulator is zero or negative, 2·K1 is added and `idx` stays unchanged. `adv` is low on the next cycle.
- R7: `idx` never advances past K1. Once it equals K1, a positive-accumulator tick still applies the 2·K2 step but raises no `adv`.
- R8: In a cycle with neither `tick` nor `line_start`, `idx` holds and `adv` is low on the next cycle.
- R9: When `line_start` and `tick` come in the same cycle, the reload wins and the tick is dropped.
- R10: When `line_start` and `vsync` come in the same cycle, the reload uses the seed being transferred that cycle.
- R11: Outputs are registered. A decision made at a clock edge is visible right after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Holding-register write strobe |
| cfg_sel | input | 2 | Write target: 0 K1, 1 K2, 2 seed, 3 none |
| cfg_data | input | 12 | Write data |
| vsync | input | 1 | Holding-to-working transfer pulse |
| line_start | input | 1 | Reload pulse: seed into accumulator, clear index |
| tick | input | 1 | One output sample is produced this cycle |
| adv | output | 1 | Input index advanced on the last tick |
| idx | output | 11 | Current input sample index |

## Verification
A corrupted accumulator does not show directly. It shows at the ports as a shifted `adv` pattern, usually within two or three ticks, because each wrong sign flips one repeat/advance decision. A wrong working constant shows up in the first line after the sync that should have loaded it. A broken clamp shows as `idx` passing K1 near the end of an over-long line. The scoreboard therefore compares `adv` and `idx` on every cycle of several complete lines, rather than only at line ends.

// File: rtl/dda_pkg.sv
package dda_pkg;
   typedef enum logic [1:0] {
      SEL_K1   = 2'd0,
      SEL_K2   = 2'd1,
      SEL_SEED = 2'd2,
      SEL_NONE = 2'd3
   } dda_sel_e;
endpackage

// File: rtl/dda_cfg_bank.sv
module dda_cfg_bank
   import dda_pkg::*;
#(
   parameter int CNT_W  = 11,
   parameter int SEED_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_sel,
   input  logic [SEED_W-1:0] cfg_data,
   input  logic              vsync,
   output logic [CNT_W-1:0]  sh_k1,
   output logic [CNT_W-1:0]  act_k1,
   output logic [CNT_W-1:0]  act_k2,
   output logic [SEED_W-1:0] act_seed,
   output logic [SEED_W-1:0] reload_seed
);
   logic [CNT_W-1:0]  sh_k2;
   logic [SEED_W-1:0] sh_seed;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_k1    <= '0;
         sh_k2    <= '0;
         sh_seed  <= '0;
         act_k1   <= '0;
         act_k2   <= '0;
         act_seed <= '0;
      end else begin
         if (cfg_we) begin
            case (dda_sel_e'(cfg_sel))
               SEL_K1:   sh_k1   <= cfg_data[CNT_W-1:0];
               SEL_K2:   sh_k2   <= cfg_data[CNT_W-1:0];
               SEL_SEED: sh_seed <= cfg_data;
               default:  ;
            endcase
         end
         if (vsync) begin
            act_k1   <= sh_k1;
            act_k2   <= sh_k2;
            act_seed <= sh_seed;
         end
      end
   end

   // a reload coinciding with the transfer sees the incoming seed
   assign reload_seed = vsync ? sh_seed : act_seed;
endmodule

// File: rtl/dda_step_core.sv
module dda_step_core #(
   parameter int CNT_W  = 11,
   parameter int SEED_W = 12,
   parameter int ACC_W  = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_start,
   input  logic              tick,
   input  logic [CNT_W-1:0]  k1,
   input  logic [CNT_W-1:0]  k2,
   input  logic [SEED_W-1:0] seed,
   output logic              adv,
   output logic [CNT_W-1:0]  idx
);
   localparam int K_EXT = ACC_W - CNT_W - 1;
   localparam int S_EXT = ACC_W - SEED_W;

   generate
      if (ACC_W < CNT_W + 2) begin : g_bad_acc
         $error("ACC_W must be at least CNT_W+2");
      end
      if (SEED_W < CNT_W + 1) begin : g_bad_seed
         $error("SEED_W must be at least CNT_W+1");
      end
   endgenerate

   logic [ACC_W-1:0] acc_q;
   logic [ACC_W-1:0] k1_x2, k2_x2, seed_x;
   logic             acc_pos, room;

   assign k1_x2   = {{K_EXT{1'b0}}, k1, 1'b0};
   assign k2_x2   = {{K_EXT{k2[CNT_W-1]}}, k2, 1'b0};
   assign seed_x  = {{S_EXT{seed[SEED_W-1]}}, seed};
   assign acc_pos = !acc_q[ACC_W-1] && (acc_q != '0);
   assign room    = idx < k1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q <= '0;
         idx   <= '0;
         adv   <= 1'b0;
      end else if (line_start) begin
         acc_q <= seed_x;
         idx   <= '0;
         adv   <= 1'b0;
      end else if (tick) begin
         if (acc_pos) begin
            acc_q <= acc_q + k2_x2;
            adv   <= room;
            if (room) idx <= idx + 1'b1;
         end else begin
            acc_q <= acc_q + k1_x2;
            adv   <= 1'b0;
         end
      end else begin
         adv <= 1'b0;
      end
   end
endmodule

// File: rtl/dda_stretch_stepper.sv
module dda_stretch_stepper #(
   parameter int CNT_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [1:0]       cfg_sel,
   input  logic [CNT_W:0]   cfg_data,
   input  logic             vsync,
   input  logic             line_start,
   input  logic             tick,
   output logic             adv,
   output logic [CNT_W-1:0] idx
);
   localparam int SEED_W = CNT_W + 1;
   localparam int ACC_W  = CNT_W + 2;

   logic [CNT_W-1:0]  sh_k1, act_k1, act_k2;
   logic [SEED_W-1:0] act_seed, reload_seed;

   dda_cfg_bank #(.CNT_W(CNT_W), .SEED_W(SEED_W)) bank_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_data(cfg_data), .vsync(vsync), .sh_k1(sh_k1),
      .act_k1(act_k1), .act_k2(act_k2), .act_seed(act_seed),
      .reload_seed(reload_seed)
   );

   dda_step_core #(.CNT_W(CNT_W), .SEED_W(SEED_W), .ACC_W(ACC_W)) core_i (
      .clk(clk), .rst_n(rst_n), .line_start(line_start), .tick(tick),
      .k1(act_k1), .k2(act_k2), .seed(reload_seed), .adv(adv), .idx(idx)
   );
endmodule

// File: rtl/dda_stretch_stepper_chk.sv
module dda_stretch_stepper_chk #(
   parameter int CNT_W = 11
) (
   input logic             clk,
   input logic             rst_n,
   input logic             vsync,
   input logic             line_start,
   input logic             tick,
   input logic             adv,
   input logic [CNT_W-1:0] idx,
   input logic [CNT_W-1:0] sh_k1,
   input logic [CNT_W-1:0] act_k1
);
   // R4
   reload_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      line_start |=> (idx == '0) && !adv);
   // R5
   adv_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      adv |-> idx == $past(idx) + 1'b1);
   // R7
   idx_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      adv |-> $past(idx) < $past(act_k1));
   // R8
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !line_start) |=> !adv && $stable(idx));
   // R9
   adv_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      adv |-> $past(tick) && !$past(line_start));
   // R3
   shadow_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vsync |=> act_k1 == $past(sh_k1));
   // R2
   active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !vsync |=> $stable(act_k1));
endmodule

bind dda_stretch_stepper dda_stretch_stepper_chk #(.CNT_W(CNT_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .vsync(vsync), .line_start(line_start),
   .tick(tick), .adv(adv), .idx(idx), .sh_k1(sh_k1), .act_k1(act_k1)
);

// File: tb/dda_stretch_stepper_tb_top.sv
`timescale 1ns/1ps
module dda_stretch_stepper_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_sel = 2'd0;
   logic [11:0] cfg_data = '0;
   logic        vsync = 1'b0, line_start = 1'b0, tick = 1'b0;
   logic        adv;
   logic [10:0] idx;

   int checks = 0, errors = 0;
   bit q_adv[$];
   int q_idx[$];
   string q_tag[$];

   // reference state
   int sk1 = 0, sk2 = 0, sseed = 0, ak1 = 0, ak2 = 0, aseed = 0;
   int m_acc = 0, m_idx = 0;
   bit done = 0;

   always #2 clk = ~clk;

   dda_stretch_stepper dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_data(cfg_data), .vsync(vsync), .line_start(line_start),
      .tick(tick), .adv(adv), .idx(idx)
   );

   function automatic int sx(input int v, input int w);
      return (v >= (1 << (w-1))) ? v - (1 << w) : v;
   endfunction

   task automatic cyc(input bit t, input bit rl, input bit vs, input bit we,
                      input int sel, input int d, input string tag);
      bit e_adv;
      int nk1, nk2, nseed;
      @(negedge clk);
      tick = t; line_start = rl; vsync = vs; cfg_we = we;
      cfg_sel = sel[1:0]; cfg_data = d[11:0];
      nk1 = vs ? sk1 : ak1; nk2 = vs ? sk2 : ak2; nseed = vs ? sseed : aseed;
      e_adv = 0;
      if (rl) begin
         m_acc = sx(nseed, 12); m_idx = 0;
      end else if (t) begin
         if (m_acc > 0) begin
            e_adv = (m_idx < ak1);
            if (e_adv) m_idx++;
            m_acc += 2 * sx(ak2, 11);
         end else begin
            m_acc += 2 * ak1;
         end
      end
      if (we) begin
         if (sel == 0) sk1 = d & 11'h7FF;
         else if (sel == 1) sk2 = d & 11'h7FF;
         else if (sel == 2) sseed = d & 12'hFFF;
      end
      ak1 = nk1; ak2 = nk2; aseed = nseed;
      q_adv.push_back(e_adv); q_idx.push_back(m_idx); q_tag.push_back(tag);
   endtask

   task automatic wr(input int sel, input int d);
      cyc(0, 0, 0, 1, sel, d, "R2");
   endtask

   // monitor: one expected item per driven cycle, checked after the edge
   always @(posedge clk) begin
      #1;
      if (q_adv.size() > 0) begin
         bit ea; int ei; string et;
         ea = q_adv.pop_front(); ei = q_idx.pop_front(); et = q_tag.pop_front();
         checks++;
         if (adv !== ea || idx !== ei[10:0]) begin
            errors++;
            $display("FAIL %s adv=%0b idx=%0d expected adv=%0b idx=%0d",
                     et, adv, idx, ea, ei);
         end
      end
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset values
      checks++;
      if (adv !== 1'b0 || idx !== 11'd0) begin
         errors++;
         $display("FAIL R1 adv=%0b idx=%0d expected adv=0 idx=0", adv, idx);
      end
      rst_n = 1'b1;
      // R2: 2 in -> 4 out, held in the holding copies only
      wr(0, 1); wr(1, 11'h7FE); wr(2, 12'hFFF); wr(3, 12'h555);
      cyc(0, 1, 0, 0, 0, 0, "R2");
      for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0, 0, 0, "R2");
      // R3 transfer, then R4 reload, R5/R6/R7 stepping
      cyc(0, 0, 1, 0, 0, 0, "R3");
      cyc(0, 1, 0, 0, 0, 0, "R4");
      for (int i = 0; i < 8; i++) cyc(1, 0, 0, 0, 0, 0, "R5");
      // R8 idle holds
      for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 0, 0, "R8");
      // R10: 5 in -> 8 out, transfer and reload together
      wr(0, 4); wr(1, 11'h7FD); wr(2, 1);
      cyc(0, 1, 1, 0, 0, 0, "R10");
      for (int i = 0; i < 11; i++) cyc(1, 0, 0, 0, 0, 0, "R7");
      // R9 reload beats tick
      cyc(1, 1, 0, 0, 0, 0, "R9");
      for (int i = 0; i < 4; i++) cyc(1, 0, 0, 0, 0, 0, "R6");
      cyc(0, 0, 0, 0, 0, 0, "R11");
      // R3: write during sync cycle stays pending; 3 in -> 7 out
      wr(0, 2); wr(1, 11'h7FC);
      cyc(0, 0, 1, 1, 2, 12'hFFE, "R3");
      cyc(0, 1, 1, 0, 0, 0, "R3");
      for (int i = 0; i < 9; i++) cyc(1, 0, 0, 0, 0, 0, "R5");
      cyc(0, 0, 0, 0, 0, 0, "R8");
      cyc(0, 0, 0, 0, 0, 0, "R8");
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule